// File: doc/BRIEF.md
# Pad Function Multiplexer

This block sits between four on-chip peripheral functions and a single bidirectional IO pad. Each function presents a data output, an output enable and a data input, all as plain digital signals. A registered two-bit select value decides which function owns the pad. The owning function's data and enable are forwarded to the pad ring. The level read back from the pad is returned to the owning function only, and every other function sees a fixed idle level.

The only tri-state point is in the pad ring, which sits outside this block. The block gives the ring a data bit and a drive enable, and it takes back the sampled pad level. Pull resistors are not modelled here. Instead, a pull-enable bit and a pull-direction bit are held in configuration registers and exported to the ring.

When the selection changes, the new owner's output enable is masked for one clock. This prevents a glitch on the pad while ownership moves from one function to another.

Top module: `pad_func_mux`

## Requirements
- R1: After reset the select register holds 0, the pull enable and pull direction both read 1, and the pad stays undriven until function 0 raises its enable.
- R2: `pad_o` always equals bit `sel` of `fn_out`, where `sel` is the registered select value (function k is bit k).
- R3: Outside the masked cycle of R7, `pad_oe` equals bit `sel` of `fn_oe`.
- R4: Bit `sel` of `fn_in` follows `pad_i` combinationally.
- R5: Every bit of `fn_in` other than bit `sel` holds its idle value, which is 1 for all functions by default.
- R6: A write (`cfg_we` high at a rising edge) loads `cfg_sel`, and the new selection steers the pad from that edge onward.
- R7: In the first cycle after a write that changes the select value, `pad_oe` is 0. A write that keeps the same select value does not mask the enable.
- R8: The same write loads `cfg_pull_en` and `cfg_pull_up`, which appear on `pull_en` and `pull_up` after that edge.
- R9: While `cfg_we` is low, changes on `cfg_sel`, `cfg_pull_en` and `cfg_pull_up` leave all configuration outputs unchanged.
- R10: While the selected function drives the pad, its input still returns the pad level, so the function can read back what it drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Select value to write |
| cfg_pull_en | input | 1 | Pull enable to write |
| cfg_pull_up | input | 1 | Pull direction to write (1 = up) |
| fn_out | input | 4 | Data output of each function |
| fn_oe | input | 4 | Output enable of each function |
| fn_in | output | 4 | Data input returned to each function |
| pad_o | output | 1 | Data toward the pad driver |
| pad_oe | output | 1 | Drive enable toward the pad driver |
| pad_i | input | 1 | Level sampled from the pad |
| pull_en | output | 1 | Pull resistor enable for the pad ring |
| pull_up | output | 1 | Pull direction for the pad ring |

## Verification
The assertions assume that configuration writes occur only after reset is released, and that the function and pad inputs are settled at every clock edge. The bench meets these conditions. It changes the configuration inputs only half a clock before an edge, and it changes the data and enable patterns only between edges while the select value is held. The bench models the pad ring as a resolved level: the driven value when enabled, otherwise an external level chosen by the bench. This lets read-back and idle routing be tested against the real pad level.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

  typedef struct packed {
    logic en;
    logic up;
  } pull_cfg_t;

  localparam pull_cfg_t PULL_RESET = '{en: 1'b1, up: 1'b1};

  // width of a select field able to address n functions
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // value seen by function idx given its ownership
  function automatic logic route_in(input logic owned, input logic pad_lvl,
                                    input logic idle_lvl);
    return owned ? pad_lvl : idle_lvl;
  endfunction

endpackage

// File: rtl/pmx_cfg_regs.sv
module pmx_cfg_regs
  import pmx_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  pull_cfg_t        cfg_pull,
  output logic [SEL_W-1:0] sel_q,
  output pull_cfg_t        pull_q,
  output logic             blank_q
);

  logic sel_change;
  assign sel_change = cfg_we && (cfg_sel != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      pull_q  <= PULL_RESET;
      blank_q <= 1'b0;
    end else begin
      blank_q <= sel_change;
      if (cfg_we) begin
        sel_q  <= cfg_sel;
        pull_q <= cfg_pull;
      end
    end
  end

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (sel_q == '0 && pull_q == PULL_RESET && !blank_q));

  p_write_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (sel_q == $past(cfg_sel)));

  p_pull_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (pull_q == $past(cfg_pull)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(sel_q) && $stable(pull_q)));

  p_blank_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> blank_q);

endmodule

// File: rtl/pmx_out_mux.sv
module pmx_out_mux #(
  parameter int NUM_FUNC = 4,
  parameter int SEL_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FUNC-1:0] fn_out,
  input  logic [NUM_FUNC-1:0] fn_oe,
  input  logic [SEL_W-1:0]    sel,
  input  logic                blank,
  output logic                pad_o,
  output logic                pad_oe
);

  logic [NUM_FUNC-1:0] sel_hot;
  logic                oe_raw;

  for (genvar k = 0; k < NUM_FUNC; k++) begin : g_hot
    assign sel_hot[k] = (sel == SEL_W'(k));
  end

  assign pad_o  = |(fn_out & sel_hot);
  assign oe_raw = |(fn_oe & sel_hot);
  assign pad_oe = oe_raw && !blank;

  p_onehot_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_hot));

  p_oe_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> fn_oe[sel]);

  p_data_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pad_o == fn_out[sel]);

  p_oe_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !pad_oe);

endmodule

// File: rtl/pmx_in_demux.sv
module pmx_in_demux
  import pmx_pkg::*;
#(
  parameter int                  NUM_FUNC = 4,
  parameter int                  SEL_W    = 2,
  parameter logic [NUM_FUNC-1:0] IDLE_VAL = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pad_i,
  input  logic [SEL_W-1:0]    sel,
  output logic [NUM_FUNC-1:0] fn_in
);

  for (genvar k = 0; k < NUM_FUNC; k++) begin : g_route
    logic owned;
    assign owned    = (sel == SEL_W'(k));
    assign fn_in[k] = route_in(owned, pad_i, IDLE_VAL[k]);

    p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !owned |-> (fn_in[k] == IDLE_VAL[k]));

    p_follow_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      owned |-> (fn_in[k] == pad_i));
  end

endmodule

// File: rtl/pad_func_mux.sv
module pad_func_mux
  import pmx_pkg::*;
#(
  parameter int                  NUM_FUNC = 4,
  parameter logic [NUM_FUNC-1:0] IDLE_VAL = '1,
  localparam int                 SEL_W    = sel_width(NUM_FUNC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic                cfg_pull_en,
  input  logic                cfg_pull_up,
  input  logic [NUM_FUNC-1:0] fn_out,
  input  logic [NUM_FUNC-1:0] fn_oe,
  output logic [NUM_FUNC-1:0] fn_in,
  output logic                pad_o,
  output logic                pad_oe,
  input  logic                pad_i,
  output logic                pull_en,
  output logic                pull_up
);

  logic [SEL_W-1:0] sel_q;
  pull_cfg_t        pull_q;
  pull_cfg_t        pull_wr;
  logic             blank_q;

  assign pull_wr = '{en: cfg_pull_en, up: cfg_pull_up};

  pmx_cfg_regs #(.SEL_W(SEL_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_pull (pull_wr),
    .sel_q    (sel_q),
    .pull_q   (pull_q),
    .blank_q  (blank_q)
  );

  pmx_out_mux #(.NUM_FUNC(NUM_FUNC), .SEL_W(SEL_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .fn_out (fn_out),
    .fn_oe  (fn_oe),
    .sel    (sel_q),
    .blank  (blank_q),
    .pad_o  (pad_o),
    .pad_oe (pad_oe)
  );

  pmx_in_demux #(.NUM_FUNC(NUM_FUNC), .SEL_W(SEL_W), .IDLE_VAL(IDLE_VAL)) u_in (
    .clk   (clk),
    .rst_n (rst_n),
    .pad_i (pad_i),
    .sel   (sel_q),
    .fn_in (fn_in)
  );

  assign pull_en = pull_q.en;
  assign pull_up = pull_q.up;

  p_switch_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> !pad_oe);

  p_reset_undriven_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !fn_oe[0]) |-> !pad_oe);

  p_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (fn_in[sel_q] == pad_i));

endmodule

// File: tb/pad_func_mux_bench.sv
module pad_func_mux_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic       cfg_pull_en = 1'b0;
  logic       cfg_pull_up = 1'b0;
  logic [3:0] fn_out = 4'd0;
  logic [3:0] fn_oe = 4'd0;
  logic [3:0] fn_in;
  logic       pad_o, pad_oe, pad_i;
  logic       pull_en, pull_up;
  logic       ext_lvl = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  // pad ring model: driven level when enabled, otherwise external level
  assign pad_i = pad_oe ? pad_o : ext_lvl;

  pad_func_mux u_pad_func_mux (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_pull_en(cfg_pull_en), .cfg_pull_up(cfg_pull_up),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in),
    .pad_o(pad_o), .pad_oe(pad_oe), .pad_i(pad_i),
    .pull_en(pull_en), .pull_up(pull_up)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // drive at negedge, commit at the following rising edge, return 2 ns after it
  task automatic cfg_write(input logic [1:0] s, input logic pe, input logic pu);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_pull_en = pe; cfg_pull_up = pu;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [1:0] order [4];
    logic [1:0] prev;
    order[0] = 2'd1; order[1] = 2'd2; order[2] = 2'd3; order[3] = 2'd0;

    fn_out = 4'b0001; fn_oe = 4'b0000; ext_lvl = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 pull_en", pull_en, 1);
    chk("R1 pull_up", pull_up, 1);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 sel0 pad_o", pad_o, 1);
    chk("R5 idle after reset", fn_in, 4'b1110);

    // R8: pull write with unchanged select; R7: no masking on same select
    fn_oe = 4'b0001;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_pull_en = 1'b0; cfg_pull_up = 1'b0;
    #1;
    chk("R8 before edge", {pull_en, pull_up}, 2'b11);
    @(posedge clk); #2;
    cfg_we = 1'b0;
    chk("R8 after edge", {pull_en, pull_up}, 2'b00);
    chk("R7 same sel not masked", pad_oe, 1);

    // R9: inputs ignored without strobe
    @(negedge clk);
    cfg_sel = 2'd3; cfg_pull_en = 1'b1; cfg_pull_up = 1'b1; fn_out = 4'b0001;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 pull held", {pull_en, pull_up}, 2'b00);
    chk("R9 sel held", pad_o, 1);

    prev = 2'd0;
    foreach (order[j]) begin
      logic [1:0] s;
      s = order[j];
      fn_oe = 4'hF;
      fn_out = 4'b0001 << s;
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_pull_en = s[0]; cfg_pull_up = s[1];
      #1;
      // R6: old owner still steers before the edge
      chk("R6 before edge", pad_o, (s == prev) ? 1 : 0);
      @(posedge clk); #2;
      cfg_we = 1'b0;
      chk("R6 new owner", pad_o, 1);
      chk("R7 masked cycle", pad_oe, 0);
      chk("R8 pull per sel", {pull_en, pull_up}, {s[0], s[1]});
      @(posedge clk); #2;
      chk("R3 unmasked", pad_oe, 1);
      for (int p = 0; p < 256; p++) begin
        logic eo, ee, lvl;
        logic [3:0] ein;
        fn_out = p[3:0]; fn_oe = p[7:4]; ext_lvl = p[0] ^ p[5];
        #1;
        eo  = (p >> s) & 1;
        ee  = (p >> (4 + s)) & 1;
        lvl = ee ? eo : (p[0] ^ p[5]);
        ein = 4'hF;
        ein[s] = lvl;
        chk("R2 pad_o", pad_o, eo);
        chk("R3 pad_oe", pad_oe, ee);
        chk("R4 owner input", fn_in[s], lvl);
        chk("R5 idle inputs", fn_in | (4'b0001 << s), 4'hF);
        chk("R4 R5 full vector", fn_in, ein);
      end
      // R10: read back while driving against an opposing external level
      for (int v = 0; v < 2; v++) begin
        fn_oe = 4'b0001 << s;
        fn_out = v[0] ? (4'b0001 << s) : 4'b0000;
        ext_lvl = ~v[0];
        #1;
        chk("R10 readback", fn_in[s], v[0]);
      end
      prev = s;
    end

    // R1 again via a second reset: pad undriven with enables low
    fn_oe = 4'b0000;
    cfg_write(2'd2, 1'b0, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R1 re-reset pulls", {pull_en, pull_up}, 2'b11);
    fn_out = 4'b0001;
    #1;
    chk("R1 re-reset sel", pad_o, 1);
    chk("R1 re-reset undriven", pad_oe, 0);

    finish_run();
  end

endmodule